// File: doc/BRIEF.md
# Stop-Mode Standby and Wakeup Controller

This block puts a small processor subsystem into a deep stop state and brings it back out. Software first programs a power-mode field with the stop encoding, then writes a standby trigger bit. The block then switches off the main oscillator enable and the CPU and peripheral clock enables. Peripherals that run from an external clock are not gated by this block. While stopped, the block runs from an always-on clock and watches eight maskable interrupt sources and three reset requests. All of these inputs pass through two-flop synchronizers before they are used.

A wake event starts a stabilization countdown whose length comes from a programmable register. When the countdown ends, the clocks come back and a one-cycle completion pulse tells the CPU how to continue. There are three outcomes. It can take the waking interrupt. It can resume at the instruction after the stop instruction and leave the request pending. Or it can treat the wake as a reset. Waking and acknowledging are decided separately. Any unmasked request ends stop mode. The request is taken only if its priority beats that of the service routine that was running when stop was entered.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is in run (status 0), all three clock enables are high, no completion pulse is present, and the stabilization length holds the STAB_RST parameter.
- R2: A write to address 0 with bit 2 (trigger) set enters stop (status 1) one clock later, but only if the mode field already stored in bits 1:0 equals 2'b01. A trigger write while the stored mode has any other value is ignored, and the block stays in run. Bit 3 of the same address is the interrupt-wake disable. A write to address 1 sets the stabilization length.
- R3: The oscillator, CPU clock and peripheral clock enables are high in run and low in stop (status 1) and in stabilizing (status 2).
- R4: The wake sources are bits 0 to 5 (external lines), bit 6 (low-voltage interrupt) and bit 7 (slave serial-port interrupt). A source wakes the block only while its irq_mask bit is 0. A masked source leaves the block in stop.
- R5: A wake input that rises is acted on at the third rising clock edge after it changes, because it passes through two synchronizer flops.
- R6: A wake event leads to stabilizing for exactly L+1 cycles, where L is the stabilization length held when the event occurred. The block then returns to run.
- R7: The return to run is marked by wake_done high for exactly one cycle. wake_take_irq, wake_irq_id and wake_by_reset are valid only in that cycle and are 0 at all other times.
- R8: When stop was entered outside a service routine, an interrupt wake is taken. When it was entered inside one, the wake is taken only if the winning level is numerically smaller than the level that was in service at entry. A smaller level means a higher priority. An equal or larger level resumes with wake_take_irq 0.
- R9: When several unmasked sources are active together, the winner is the lowest level, and a tie goes to the lowest source index.
- R10: When the wake-disable bit is 1, interrupt sources do not end stop, but a reset request still does.
- R11: Any of the three reset requests ends stop and overrides all interrupts. The result reports wake_by_reset 1, wake_take_irq 0 and wake_irq_id 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control, 1: stabilization length |
| wr_data | input | CNT_W | Write data |
| irq_ext | input | NUM_EXT | External interrupt lines |
| irq_lvi | input | 1 | Low-voltage interrupt |
| irq_csi | input | 1 | Slave serial-port interrupt |
| irq_mask | input | NUM_EXT+2 | Per-source mask, 1 = masked |
| irq_prio | input | (NUM_EXT+2)*PRIO_W | Per-source level, source i at [i*PRIO_W +: PRIO_W] |
| isr_active | input | 1 | CPU is inside a service routine |
| isr_prio | input | PRIO_W | Level of the routine in service |
| rst_pin_req | input | 1 | Reset request from the reset pin |
| rst_lvd_req | input | 1 | Reset request from low-voltage detection |
| rst_poc_req | input | 1 | Reset request from power-on clear |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Internal-clock peripheral enable |
| pm_status | output | 2 | 0 run, 1 stop, 2 stabilizing |
| wake_done | output | 1 | One-cycle return-to-run pulse |
| wake_take_irq | output | 1 | Branch to the handler of the waking request |
| wake_irq_id | output | $clog2(NUM_EXT+2) | Winning source index |
| wake_by_reset | output | 1 | Wake was caused by a reset request |

## Verification
The bench builds the block with CNT_W of 8, PRIO_W of 3, six external lines and STAB_RST of 5. The short counter width keeps each stabilization window a few cycles long, so one run can cover many stop and wake rounds. These include a zero-length window, which lasts a single cycle. The three-bit levels make it possible to set up equal, lower and higher priorities against the routine in service, as well as ties between sources.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_STOP = 2'd1,
        PM_STAB = 2'd2
    } pm_state_e;

    localparam logic [1:0] MODE_STOP_ENC = 2'b01;
    localparam int         CTL_TRIG_BIT  = 2;
    localparam int         CTL_WDIS_BIT  = 3;
    localparam int         NUM_RST_SRC   = 3;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/swc_wake_pick.sv
module swc_wake_pick #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N-1:0]    mask,
    input  logic [N*PW-1:0] prio,
    output logic            any,
    output logic [IW-1:0]   id,
    output logic [PW-1:0]   lvl
);
    always_comb begin
        any = 1'b0;
        id  = '0;
        lvl = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !mask[i] && (!any || prio[i*PW +: PW] < lvl)) begin
                any = 1'b1;
                id  = IW'(i);
                lvl = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/swc_stab_timer.sv
module swc_stab_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R6
    tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
    parameter int NUM_EXT  = 6,
    parameter int PRIO_W   = 3,
    parameter int CNT_W    = 16,
    parameter int STAB_RST = 255
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic [NUM_EXT-1:0]              irq_ext,
    input  logic                            irq_lvi,
    input  logic                            irq_csi,
    input  logic [NUM_EXT+1:0]              irq_mask,
    input  logic [(NUM_EXT+2)*PRIO_W-1:0]   irq_prio,
    input  logic                            isr_active,
    input  logic [PRIO_W-1:0]               isr_prio,
    input  logic                            rst_pin_req,
    input  logic                            rst_lvd_req,
    input  logic                            rst_poc_req,
    output logic                            osc_en,
    output logic                            cpu_clk_en,
    output logic                            per_clk_en,
    output logic [1:0]                      pm_status,
    output logic                            wake_done,
    output logic                            wake_take_irq,
    output logic [$clog2(NUM_EXT+2)-1:0]    wake_irq_id,
    output logic                            wake_by_reset
);
    import swc_pkg::*;

    localparam int NSRC = NUM_EXT + 2;
    localparam int ID_W = $clog2(NSRC);

    typedef struct packed {
        pm_state_e         st;
        logic [1:0]        mode;
        logic              wdis;
        logic [CNT_W-1:0]  stab;
        logic              isr;
        logic [PRIO_W-1:0] cur;
        logic              take;
        logic [ID_W-1:0]   id;
        logic              byrst;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [NSRC-1:0]        irq_s;
    logic [NUM_RST_SRC-1:0] rst_s;
    logic                   pick_any;
    logic [ID_W-1:0]        pick_id;
    logic [PRIO_W-1:0]      pick_lvl;
    logic                   tmr_load, tmr_zero;

    swc_sync #(.W(NSRC)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .d({irq_csi, irq_lvi, irq_ext}), .q(irq_s));

    swc_sync #(.W(NUM_RST_SRC)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .d({rst_poc_req, rst_lvd_req, rst_pin_req}), .q(rst_s));

    swc_wake_pick #(.N(NSRC), .PW(PRIO_W), .IW(ID_W)) u_pick (
        .req(irq_s), .mask(irq_mask), .prio(irq_prio),
        .any(pick_any), .id(pick_id), .lvl(pick_lvl));

    swc_stab_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(r_q.stab), .zero(tmr_zero));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;

        unique case (r_q.st)
            PM_RUN: begin
                if (wr_en && !wr_addr && wr_data[CTL_TRIG_BIT] && r_q.mode == MODE_STOP_ENC) begin
                    r_d.st  = PM_STOP;
                    r_d.isr = isr_active;
                    r_d.cur = isr_prio;
                end
            end
            PM_STOP: begin
                if (|rst_s) begin
                    r_d.st    = PM_STAB;
                    tmr_load  = 1'b1;
                    r_d.byrst = 1'b1;
                    r_d.take  = 1'b0;
                    r_d.id    = '0;
                end else if (!r_q.wdis && pick_any) begin
                    r_d.st    = PM_STAB;
                    tmr_load  = 1'b1;
                    r_d.byrst = 1'b0;
                    r_d.id    = pick_id;
                    r_d.take  = !r_q.isr || (pick_lvl < r_q.cur);
                end
            end
            PM_STAB: begin
                if (tmr_zero) begin
                    r_d.st   = PM_RUN;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = PM_RUN;
        endcase

        if (wr_en) begin
            if (!wr_addr) begin
                r_d.mode = wr_data[1:0];
                r_d.wdis = wr_data[CTL_WDIS_BIT];
            end else begin
                r_d.stab = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= PM_RUN;
            r_q.stab <= CNT_W'(STAB_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign osc_en        = (r_q.st == PM_RUN);
    assign cpu_clk_en    = (r_q.st == PM_RUN);
    assign per_clk_en    = (r_q.st == PM_RUN);
    assign pm_status     = r_q.st;
    assign wake_done     = r_q.done;
    assign wake_take_irq = r_q.done & r_q.take;
    assign wake_irq_id   = r_q.done ? r_q.id : '0;
    assign wake_by_reset = r_q.done & r_q.byrst;

    // R2
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PM_STOP && $past(r_q.st) == PM_RUN) |->
        $past(wr_en && !wr_addr && wr_data[CTL_TRIG_BIT]));

    // R3
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> (pm_status == PM_STOP));

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> ($past(r_q.st) == PM_STAB));

    // R10
    wdis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PM_STOP && r_q.wdis && !(|rst_s)) |=> (r_q.st == PM_STOP));

    // R11
    rst_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && wake_by_reset) |-> (!wake_take_irq && wake_irq_id == '0));
endmodule

// File: tb/stop_wake_ctrl_tb.sv
module stop_wake_ctrl_tb;
    localparam int NUM_EXT  = 6;
    localparam int PRIO_W   = 3;
    localparam int CNT_W    = 8;
    localparam int STAB_RST = 5;
    localparam int NSRC     = NUM_EXT + 2;
    localparam int ID_W     = $clog2(NSRC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [NUM_EXT-1:0] irq_ext = '0;
    logic irq_lvi = 1'b0, irq_csi = 1'b0;
    logic [NSRC-1:0] irq_mask = '0;
    logic [NSRC*PRIO_W-1:0] irq_prio = '0;
    logic isr_active = 1'b0;
    logic [PRIO_W-1:0] isr_prio = '0;
    logic rst_pin_req = 1'b0, rst_lvd_req = 1'b0, rst_poc_req = 1'b0;
    logic osc_en, cpu_clk_en, per_clk_en, wake_done, wake_take_irq, wake_by_reset;
    logic [1:0] pm_status;
    logic [ID_W-1:0] wake_irq_id;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    stop_wake_ctrl #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W), .CNT_W(CNT_W), .STAB_RST(STAB_RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ext(irq_ext), .irq_lvi(irq_lvi), .irq_csi(irq_csi), .irq_mask(irq_mask),
        .irq_prio(irq_prio), .isr_active(isr_active), .isr_prio(isr_prio),
        .rst_pin_req(rst_pin_req), .rst_lvd_req(rst_lvd_req), .rst_poc_req(rst_poc_req),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .pm_status(pm_status), .wake_done(wake_done), .wake_take_irq(wake_take_irq),
        .wake_irq_id(wake_irq_id), .wake_by_reset(wake_by_reset));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_st, m_mode, m_wdis, m_stab, m_isr, m_cur, m_cnt, m_take, m_id, m_rst, m_done;
    int ms1[$], ms2[$];
    int best, blv;
    bit [NSRC-1:0] syn1, syn2;
    bit [2:0] rsy1, rsy2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_wdis = 0; m_stab = STAB_RST; m_isr = 0; m_cur = 0;
            m_cnt = 0; m_take = 0; m_id = 0; m_rst = 0; m_done = 0;
            syn1 = '0; syn2 = '0; rsy1 = '0; rsy2 = '0;
        end else begin
            m_done = 0;
            case (m_st)
                0: if (wr_en && !wr_addr && wr_data[2] && m_mode == 1) begin
                    m_st = 1; m_isr = isr_active; m_cur = isr_prio;
                end
                1: begin
                    if (rsy2 != 0) begin
                        m_st = 2; m_cnt = m_stab; m_rst = 1; m_take = 0; m_id = 0;
                    end else if (m_wdis == 0) begin
                        best = -1; blv = 0;
                        for (int i = 0; i < NSRC; i++)
                            if (syn2[i] && !irq_mask[i] &&
                                (best < 0 || int'(irq_prio[i*PRIO_W +: PRIO_W]) < blv)) begin
                                best = i; blv = irq_prio[i*PRIO_W +: PRIO_W];
                            end
                        if (best >= 0) begin
                            m_st = 2; m_cnt = m_stab; m_rst = 0; m_id = best;
                            m_take = (m_isr == 0 || blv < m_cur) ? 1 : 0;
                        end
                    end
                end
                default: if (m_cnt == 0) begin m_st = 0; m_done = 1; end else m_cnt--;
            endcase
            if (wr_en) begin
                if (!wr_addr) begin m_mode = wr_data[1:0]; m_wdis = wr_data[3]; end
                else m_stab = wr_data;
            end
            syn2 = syn1; syn1 = {irq_csi, irq_lvi, irq_ext};
            rsy2 = rsy1; rsy1 = {rst_poc_req, rst_lvd_req, rst_pin_req};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(pm_status == m_st, "R3 status", pm_status, m_st);
            chk(cpu_clk_en == (m_st == 0) && osc_en == (m_st == 0) && per_clk_en == (m_st == 0),
                "R3 clock enables", cpu_clk_en, m_st == 0);
            chk(wake_done == m_done, "R7 done pulse", wake_done, m_done);
            chk(wake_take_irq == (m_done && m_take), "R8 take", wake_take_irq, m_done && m_take);
            chk(int'(wake_irq_id) == (m_done ? m_id : 0), "R9 id", wake_irq_id, m_done ? m_id : 0);
            chk(wake_by_reset == (m_done && m_rst), "R11 by reset", wake_by_reset, m_done && m_rst);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic enter_stop(input bit isr, input int lvl, input bit wdis);
        isr_active = isr; isr_prio = PRIO_W'(lvl);
        wr(1'b0, 1 | (int'(wdis) << 3));
        wr(1'b0, 1 | 4 | (int'(wdis) << 3));
        isr_active = 1'b0;
        chk(pm_status == 2'd1, "R2 stop entered", pm_status, 1);
    endtask

    task automatic wait_done(input bit tk, input int id, input bit br, input string tag);
        int n = 0;
        while (!wake_done && n < 200) begin @(negedge clk); n++; end
        chk(wake_done && wake_take_irq == tk && int'(wake_irq_id) == id && wake_by_reset == br,
            tag, {wake_take_irq, 4'(wake_irq_id), wake_by_reset}, {tk, 4'(id), br});
    endtask

    task automatic set_lvl(input int src, input int lvl);
        irq_prio[src*PRIO_W +: PRIO_W] = PRIO_W'(lvl);
    endtask

    task automatic clear_all();
        irq_ext = '0; irq_lvi = 1'b0; irq_csi = 1'b0;
        rst_pin_req = 1'b0; rst_lvd_req = 1'b0; rst_poc_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pm_status == 0 && cpu_clk_en && osc_en && per_clk_en && !wake_done,
            "R1 reset state", pm_status, 0);

        // R2 trigger with non-stop mode is ignored
        wr(1'b0, 4);
        @(negedge clk);
        chk(pm_status == 0 && cpu_clk_en, "R2 trigger ignored", pm_status, 0);

        // R1 default length: STAB_RST+1 cycles of stabilizing
        enter_stop(1'b0, 0, 1'b0);
        irq_ext[4] = 1'b1; set_lvl(4, 2);
        while (pm_status != 2) @(negedge clk);
        n = 0;
        while (pm_status == 2) begin n++; @(negedge clk); end
        chk(n == STAB_RST + 1, "R1 default stab length", n, STAB_RST + 1);
        chk(wake_done && wake_take_irq && wake_irq_id == 4, "R4 wake ext4", wake_irq_id, 4);
        clear_all();

        // R4 masked source ignored, R5 sync latency, R6 length
        wr(1'b1, 3);
        enter_stop(1'b0, 0, 1'b0);
        irq_mask = 8'b0000_0100; irq_ext[2] = 1'b1;
        repeat (8) @(negedge clk);
        chk(pm_status == 1, "R4 masked stays stopped", pm_status, 1);
        set_lvl(1, 3); irq_ext[1] = 1'b1;
        n = 0;
        while (pm_status != 2 && n < 50) begin @(negedge clk); n++; end
        chk(n == 3, "R5 sync latency", n, 3);
        n = 0;
        while (pm_status == 2) begin n++; @(negedge clk); end
        chk(n == 4, "R6 stab cycles", n, 4);
        chk(wake_done && wake_take_irq && wake_irq_id == 1, "R8 take outside isr", wake_irq_id, 1);
        @(negedge clk);
        chk(!wake_done && !wake_take_irq, "R7 single pulse", wake_done, 0);
        irq_mask = '0;
        clear_all();

        // R8 equal priority inside isr resumes
        set_lvl(6, 2);
        enter_stop(1'b1, 2, 1'b0);
        irq_lvi = 1'b1;
        wait_done(1'b0, 6, 1'b0, "R8 equal level resumes");
        clear_all();

        // R8 lower priority (larger level) resumes
        set_lvl(7, 5);
        enter_stop(1'b1, 2, 1'b0);
        irq_csi = 1'b1;
        wait_done(1'b0, 7, 1'b0, "R8 lower priority resumes");
        clear_all();

        // R9 tie and winner selection, taken inside isr
        set_lvl(3, 1); set_lvl(7, 1); set_lvl(5, 4);
        enter_stop(1'b1, 2, 1'b0);
        irq_ext[3] = 1'b1; irq_ext[5] = 1'b1; irq_csi = 1'b1;
        wait_done(1'b1, 3, 1'b0, "R9 tie lowest index taken");
        clear_all();

        // R10 disable bit blocks interrupts, reset still wakes
        enter_stop(1'b0, 0, 1'b1);
        irq_ext[0] = 1'b1;
        repeat (10) @(negedge clk);
        chk(pm_status == 1, "R10 interrupts blocked", pm_status, 1);
        rst_lvd_req = 1'b1;
        wait_done(1'b0, 0, 1'b1, "R10 reset wakes despite disable");
        wr(1'b0, 0);
        clear_all();

        // R11 reset overrides simultaneous interrupt
        set_lvl(0, 0);
        enter_stop(1'b0, 0, 1'b0);
        irq_ext[0] = 1'b1; rst_poc_req = 1'b1;
        wait_done(1'b0, 0, 1'b1, "R11 reset beats interrupt");
        clear_all();

        // R11 pin reset alone, R6 zero length lasts one cycle
        wr(1'b1, 0);
        enter_stop(1'b0, 0, 1'b0);
        rst_pin_req = 1'b1;
        while (pm_status != 2) @(negedge clk);
        n = 0;
        while (pm_status == 2) begin n++; @(negedge clk); end
        chk(n == 1, "R6 zero length", n, 1);
        chk(wake_done && wake_by_reset, "R11 pin reset", wake_by_reset, 1);
        clear_all();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule